// File: doc/BRIEF.md
# Tachometer Pulse Rate Doubler and Programmable Divider

This block conditions the pulse train coming from a motor tachometer sensor. The raw sensor line is first brought into the clock domain by a two-stage synchronizer. A front-end stage then either passes the synchronized signal through unchanged or doubles its edge rate. In doubling mode, the signal is XOR-ed with a copy of itself delayed by a few cycles, so that every raw edge, rising or falling, becomes one rising edge of the conditioned signal.

The conditioned signal feeds a down-counter that divides its rising edges by an 8-bit ratio. Each time the counter expires, the block emits a one-clock event pulse. A ratio of zero switches off division: every rising and every falling edge then yields an event.

The ratio is presented as a plain value together with a write strobe. A strobe reloads the counter at once. Any event that would have fallen in the same cycle as the strobe is dropped. The current counter value is exported so that the division progress can be observed.

Top module: `tach_divider`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `count_o` is 0 and `evt_o` is 0.
- R2: With `dbl_en_i`=0 the conditioned signal equals the synchronized input. A change on `tach_raw_i` that is set up before clock edge N shows its effect on `evt_o` and `count_o` after edge N+2: two synchronizer stages plus the output register.
- R3: With `dbl_en_i`=1, each change of `tach_raw_i` in either direction produces exactly one rising edge of the conditioned signal. That edge has the same latency as in R2, provided successive input changes are more than `DBL_DELAY`+2 cycles apart.
- R4: With ratio 0 and no strobe, every rising and every falling edge of the conditioned signal gives `evt_o`=1, and `count_o` is held.
- R5: With a non-zero ratio, a falling edge of the conditioned signal changes neither `count_o` nor `evt_o`.
- R6: With a non-zero ratio and no strobe, a rising edge behaves as follows. If `count_o` > 1, it decrements the count with no event. If `count_o` ≤ 1, it raises `evt_o` and reloads the count with the ratio. A ratio of 3 therefore gives counts 3, 2, 1, 3, and the event comes with the return to 3. Right after reset the count is 0, so the first rising edge produces an event.
- R7: A cycle with `ratio_we_i`=1 loads `ratio_i` into `count_o` at that clock edge, whatever the input is doing.
- R8: In a cycle with `ratio_we_i`=1, `evt_o` is 0 after the edge. This holds even if a rising edge would have expired the counter, and the edge is not counted.
- R9: `evt_o` is high for one cycle per event. `count_o` keeps its value in every cycle that has no conditioned edge and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tach_raw_i | input | 1 | Asynchronous raw tachometer pulse line |
| dbl_en_i | input | 1 | 1 selects edge-rate doubling, 0 selects straight pass |
| ratio_i | input | 8 | Division ratio; 0 means no division |
| ratio_we_i | input | 1 | Strobe: ratio_i was just written, reload the counter |
| evt_o | output | 1 | One-cycle divided event pulse |
| count_o | output | 8 | Present down-counter value |

## Verification
A raw input change reaches `evt_o` and `count_o` after the third rising clock edge that follows it. A ratio strobe shows up after the first edge. The bench drives every input on a falling clock edge. It then samples exactly three falling edges after a raw change and one falling edge after a strobe. One falling edge later, it checks again that `evt_o` has fallen. Successive raw changes are spaced well past the doubler's delay, so each conditioned pulse settles before the next stimulus. For the collision case, the strobe is placed in the very cycle in which the expiring edge is due.

// File: rtl/tach_pkg.sv
package tach_pkg;

    localparam int TACH_RATIO_W  = 8;
    localparam int TACH_SYNC_N   = 2;
    localparam int TACH_DBL_DLY  = 2;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_LOAD   = 2'd1,
        ACT_DEC    = 2'd2,
        ACT_EXPIRE = 2'd3
    } cnt_act_e;

    function automatic edge_t find_edges(input logic cur, input logic prev);
        edge_t e;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction

endpackage

// File: rtl/tach_sync.sv
module tach_sync #(
    parameter int STAGES = tach_pkg::TACH_SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/tach_frontend.sv
module tach_frontend #(
    parameter int DBL_DELAY = tach_pkg::TACH_DBL_DLY
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    input  logic dbl_en_i,
    output logic cond_o
);
    logic [DBL_DELAY-1:0] dly;

    generate
        if (DBL_DELAY == 1) begin : g_d1
            always_ff @(posedge clk) begin
                if (rst) dly <= '0;
                else     dly <= sig_i;
            end
        end else begin : g_dn
            always_ff @(posedge clk) begin
                if (rst) dly <= '0;
                else     dly <= {dly[DBL_DELAY-2:0], sig_i};
            end
        end
    endgenerate

    // Doubling: each input edge opens a DBL_DELAY-wide high pulse.
    assign cond_o = dbl_en_i ? (sig_i ^ dly[DBL_DELAY-1]) : sig_i;

    // R3: in doubling mode, a settled input change raises the conditioned signal
    a_r3_double_rise: assert property (@(posedge clk) disable iff (rst)
        (dbl_en_i && (sig_i != dly[0]) && (dly[0] == dly[DBL_DELAY-1])) |-> cond_o);
endmodule

// File: rtl/tach_divcore.sv
module tach_divcore #(
    parameter int RATIO_W = tach_pkg::TACH_RATIO_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cond_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               ratio_we_i,
    output logic               evt_o,
    output logic [RATIO_W-1:0] count_o
);
    import tach_pkg::*;

    logic               prev_q;
    logic               evt_q;
    logic               evt_d;
    logic [RATIO_W-1:0] cnt_q;
    edge_t              edg;
    cnt_act_e           act;
    logic               bypass;

    assign edg    = find_edges(cond_i, prev_q);
    assign bypass = (ratio_i == '0);

    always_comb begin
        act   = ACT_HOLD;
        evt_d = 1'b0;
        if (ratio_we_i) begin
            act = ACT_LOAD;
        end else if (bypass) begin
            evt_d = edg.rise | edg.fall;
        end else if (edg.rise) begin
            if (cnt_q <= RATIO_W'(1)) begin
                act   = ACT_EXPIRE;
                evt_d = 1'b1;
            end else begin
                act = ACT_DEC;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            evt_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            prev_q <= cond_i;
            evt_q  <= evt_d;
            case (act)
                ACT_LOAD, ACT_EXPIRE: cnt_q <= ratio_i;
                ACT_DEC:              cnt_q <= cnt_q - RATIO_W'(1);
                default:              cnt_q <= cnt_q;
            endcase
        end
    end

    assign evt_o   = evt_q;
    assign count_o = cnt_q;

    // R4: bypass passes both edge directions
    a_r4_bypass_both: assert property (@(posedge clk) disable iff (rst)
        (!ratio_we_i && bypass && (edg.rise || edg.fall)) |=> evt_q);
    // R5: falling edges ignored while dividing
    a_r5_fall_ignored: assert property (@(posedge clk) disable iff (rst)
        (!ratio_we_i && !bypass && edg.fall) |=> (!evt_q && $stable(cnt_q)));
    // R6: a rising edge above one counts down silently
    a_r6_count_down: assert property (@(posedge clk) disable iff (rst)
        (!ratio_we_i && !bypass && edg.rise && cnt_q > RATIO_W'(1))
        |=> (!evt_q && cnt_q == $past(cnt_q) - RATIO_W'(1)));
    // R6: a rising edge at one or zero expires and reloads
    a_r6_expire: assert property (@(posedge clk) disable iff (rst)
        (!ratio_we_i && !bypass && edg.rise && cnt_q <= RATIO_W'(1))
        |=> (evt_q && cnt_q == $past(ratio_i)));
    // R7, R8: strobe loads and suppresses
    a_r8_load_masks: assert property (@(posedge clk) disable iff (rst)
        ratio_we_i |=> (!evt_q && cnt_q == $past(ratio_i)));
    // R9: count holds with no edge and no strobe
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!ratio_we_i && !edg.rise && !edg.fall) |=> (!evt_q && $stable(cnt_q)));
endmodule

// File: rtl/tach_divider.sv
module tach_divider #(
    parameter int RATIO_W   = tach_pkg::TACH_RATIO_W,
    parameter int SYNC_N    = tach_pkg::TACH_SYNC_N,
    parameter int DBL_DELAY = tach_pkg::TACH_DBL_DLY
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tach_raw_i,
    input  logic               dbl_en_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               ratio_we_i,
    output logic               evt_o,
    output logic [RATIO_W-1:0] count_o
);
    logic tach_s;
    logic cond;

    tach_sync #(.STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (tach_raw_i),
        .q_o (tach_s)
    );

    tach_frontend #(.DBL_DELAY(DBL_DELAY)) u_front (
        .clk      (clk),
        .rst      (rst),
        .sig_i    (tach_s),
        .dbl_en_i (dbl_en_i),
        .cond_o   (cond)
    );

    tach_divcore #(.RATIO_W(RATIO_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .cond_i     (cond),
        .ratio_i    (ratio_i),
        .ratio_we_i (ratio_we_i),
        .evt_o      (evt_o),
        .count_o    (count_o)
    );

    // R1: reset clears outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (count_o == '0 && !evt_o));
endmodule

// File: tb/tach_divider_tb.sv
module tach_divider_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       raw = 1'b0;
    logic       dbl = 1'b0;
    logic [7:0] ratio = 8'd0;
    logic       we = 1'b0;
    logic       evt;
    logic [7:0] cnt;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    tach_divider u_dut (
        .clk        (clk),
        .rst        (rst),
        .tach_raw_i (raw),
        .dbl_en_i   (dbl),
        .ratio_i    (ratio),
        .ratio_we_i (we),
        .evt_o      (evt),
        .count_o    (cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Raw change, result due at the third falling edge after it.
    task automatic step(input logic v, input logic e_evt, input int e_cnt, input string req);
        raw = v;
        repeat (3) @(negedge clk);
        chk({req, " evt"}, evt, e_evt);
        chk({req, " count"}, cnt, e_cnt);
        @(negedge clk);
        chk("R9 evt one cycle", evt, 0);
        repeat (6) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        ratio = v;
        we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        chk("R7 load count", cnt, v);
        chk("R8 no evt on load", evt, 0);
    endtask

    task automatic t_reset();
        chk("R1 reset count", cnt, 0);
        chk("R1 reset evt", evt, 0);
    endtask

    task automatic t_first_rise();
        ratio = 8'd4;
        step(1'b1, 1'b1, 4, "R6 first rise from zero expires");
        step(1'b0, 1'b0, 4, "R5 fall ignored");
    endtask

    task automatic t_countdown();
        wr(8'd3);
        step(1'b1, 1'b0, 2, "R6 3->2");
        step(1'b0, 1'b0, 2, "R5 fall ignored");
        step(1'b1, 1'b0, 1, "R6 2->1");
        step(1'b0, 1'b0, 1, "R2 through fall");
        step(1'b1, 1'b1, 3, "R6 expire reload 3");
        step(1'b0, 1'b0, 3, "R5 fall ignored");
    endtask

    task automatic t_hold();
        repeat (20) @(negedge clk);
        chk("R9 hold count", cnt, 3);
        chk("R9 hold evt", evt, 0);
    endtask

    task automatic t_bypass();
        wr(8'd0);
        step(1'b1, 1'b1, 0, "R4 bypass rise");
        step(1'b0, 1'b1, 0, "R4 bypass fall");
    endtask

    task automatic t_ratio1();
        wr(8'd1);
        step(1'b1, 1'b1, 1, "R6 ratio1 rise");
        step(1'b0, 1'b0, 1, "R5 ratio1 fall");
        step(1'b1, 1'b1, 1, "R6 ratio1 rise again");
        step(1'b0, 1'b0, 1, "R5 ratio1 fall again");
    endtask

    task automatic t_doubler();
        dbl = 1'b1;
        wr(8'd2);
        step(1'b1, 1'b0, 1, "R3 doubled rise counted");
        step(1'b0, 1'b1, 2, "R3 doubled fall counted");
        step(1'b1, 1'b0, 1, "R3 doubled rise counted");
        step(1'b0, 1'b1, 2, "R3 doubled fall counted");
        dbl = 1'b0;
    endtask

    task automatic t_collide();
        wr(8'd2);
        step(1'b1, 1'b0, 1, "R6 2->1");
        step(1'b0, 1'b0, 1, "R5 fall ignored");
        raw = 1'b1;
        repeat (2) @(negedge clk);
        ratio = 8'd5;
        we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        chk("R8 collide evt masked", evt, 0);
        chk("R7 collide count loaded", cnt, 5);
        @(negedge clk);
        chk("R8 collide edge consumed", evt, 0);
        chk("R8 collide count kept", cnt, 5);
        repeat (6) @(negedge clk);
        step(1'b0, 1'b0, 5, "R5 fall ignored");
        step(1'b1, 1'b0, 4, "R6 5->4 after collide");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_first_rise();
        t_countdown();
        t_hold();
        t_bypass();
        t_ratio1();
        t_doubler();
        t_collide();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule